// File: doc/BRIEF.md
# LCD Two-Phase Access Bridge

This block sits between a fast host bus and a slow byte-wide character LCD module, so the host is never held for the whole of a slow module cycle. Every module operation takes two host accesses. The first access latches the operation, which is the module select, command-or-data and read-or-write. It drives the module's enable strobe and returns at once. The second access completes the operation. For a read, it returns the byte captured from the module. The strobe then drops.

A status register shows the latch flag and the latched operation bits. Software that was interrupted between the two accesses can read this register and then either resume the pair or abort it. Two module enable strobes are served, and the address of the first access chooses which one is driven. The strobe stays high for at least `HOLD_CLKS` clocks. If the second access arrives earlier, the host is held with a wait signal.

Top module: `lcd_pair_bridge`

## Requirements
- R1: When `rst` is high at a clock edge, the next cycle shows no strobe, `lcd_doe` low, `host_wait` low, and a status value of zero.
- R2: A host access to the LCD window (address bit 3 = 0) while no pair is pending latches the operation from the address: bit 0 = 1 means a read, bit 1 = 0 means a command (`lcd_cmd`=1), and bit 2 selects the module. From the next cycle the pending flag is set. A first read returns 0x00 on `host_rdata`.
- R3: While a pair is pending, exactly one strobe is high: `lcd_e[1]` when the latched module bit is 1, and `lcd_e[0]` when it is 0. Both strobes are never high together.
- R4: For a latched write, `lcd_doe` is high and `lcd_dout` holds the first access's write data unchanged until the pair ends.
- R5: The strobe stays high for at least `HOLD_CLKS` cycles. A second access presented one cycle after the first sees `host_wait` high for `HOLD_CLKS`-1 cycles. A second access presented later than that sees no wait.
- R6: The second access completes the pair. For a latched read, `host_rdata` holds `lcd_din` as sampled at the completing edge. The pending flag clears and the strobes are low from the next cycle.
- R7: The address and write data of the second access are not used. The latched operation, `lcd_cmd` and `lcd_dout` are the ones that finish the pair.
- R8: A host read of the status register (address bit 3 = 1) returns bit0 = pending flag, bit1 = latched command select, bit2 = latched read/write, and bit3 = latched module select. The upper bits are zero.
- R9: A host write to the status register with data bit 3 set clears the pending flag and drops the strobes from the next cycle. With data bit 3 clear, the write has no effect.
- R10: A status access while a pair is pending neither waits nor completes the pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | ADDR_W | Host address: bit0 read, bit1 data, bit2 module, bit3 status |
| host_wdata | input | DATA_W | Host write data |
| host_rd | input | 1 | Host read strobe, held while `host_wait` is high |
| host_wr | input | 1 | Host write strobe, held while `host_wait` is high |
| host_rdata | output | DATA_W | Registered read data |
| host_wait | output | 1 | Holds an early second access |
| lcd_din | input | DATA_W | Data from the module |
| lcd_dout | output | DATA_W | Data to the module |
| lcd_doe | output | 1 | Output enable for `lcd_dout` |
| lcd_cmd | output | 1 | 1 = command, 0 = data |
| lcd_rw | output | 1 | 1 = read, 0 = write |
| lcd_e | output | 2 | Module enable strobes |

## Verification
The bench builds the bridge with `HOLD_CLKS` = 5. With that value, the whole wait window of an immediate second access fits in four cycles, so the bench counts it exactly. A late second access can also be made to see no wait after only a few idle cycles. `DATA_W` stays at 8, so every combination of module, command/data and read/write is covered as a full pair in the vector table, using distinct byte patterns.

// File: rtl/lcd_pair_pkg.sv
package lcd_pair_pkg;
  typedef struct packed {
    logic module_sel;
    logic is_read;
    logic is_cmd;
  } lcd_op_t;
endpackage

// File: rtl/lcd_pair_decode.sv
module lcd_pair_decode
  import lcd_pair_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int RD_BIT   = 0,
  parameter int DC_BIT   = 1,
  parameter int MOD_BIT  = 2,
  parameter int STAT_BIT = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              lcd_hit,
  output logic              stat_hit,
  output lcd_op_t           op
);
  always_comb begin
    stat_hit      = addr[STAT_BIT];
    lcd_hit       = ~addr[STAT_BIT];
    op.is_read    = addr[RD_BIT];
    op.is_cmd     = ~addr[DC_BIT];
    op.module_sel = addr[MOD_BIT];
  end
endmodule

// File: rtl/lcd_pair_hold.sv
module lcd_pair_hold #(
  parameter int HOLD_CLKS = 16,
  localparam int CNT_W = (HOLD_CLKS < 2) ? 1 : $clog2(HOLD_CLKS)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (start) cnt <= CNT_W'(HOLD_CLKS - 1);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  // R5: the hold window shrinks by one each cycle until it is spent
  assert_hold_count_R5: assert property (@(posedge clk) disable iff (rst)
    (!start && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));
  // R5: a fresh start always opens a full window
  assert_hold_load_R5: assert property (@(posedge clk) disable iff (rst)
    start |=> (HOLD_CLKS < 2 || cnt != '0));
endmodule

// File: rtl/lcd_pair_bridge.sv
module lcd_pair_bridge
  import lcd_pair_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int HOLD_CLKS = 16,
  parameter int ABORT_BIT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_rd,
  input  logic              host_wr,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_wait,
  input  logic [DATA_W-1:0] lcd_din,
  output logic [DATA_W-1:0] lcd_dout,
  output logic              lcd_doe,
  output logic              lcd_cmd,
  output logic              lcd_rw,
  output logic [1:0]        lcd_e
);
  localparam int STAT_W = 4;

  logic    lcd_hit, stat_hit, done;
  lcd_op_t op, op_q;
  logic    llat;
  logic    acc, lcd_acc, stat_acc, first, complete, abort;

  lcd_pair_decode #(.ADDR_W(ADDR_W)) dec_i (
    .addr(host_addr), .lcd_hit(lcd_hit), .stat_hit(stat_hit), .op(op)
  );

  lcd_pair_hold #(.HOLD_CLKS(HOLD_CLKS)) hold_i (
    .clk(clk), .rst(rst), .start(first), .done(done)
  );

  always_comb begin
    acc       = host_rd | host_wr;
    lcd_acc   = acc & lcd_hit;
    stat_acc  = acc & stat_hit;
    first     = lcd_acc & ~llat;
    complete  = lcd_acc & llat & done;
    abort     = host_wr & stat_hit & host_wdata[ABORT_BIT];
    host_wait = lcd_acc & llat & ~done;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      llat       <= 1'b0;
      op_q       <= '0;
      lcd_dout   <= '0;
      lcd_doe    <= 1'b0;
      lcd_e      <= 2'b00;
      host_rdata <= '0;
    end else begin
      if (abort || complete) begin
        llat    <= 1'b0;
        lcd_e   <= 2'b00;
        lcd_doe <= 1'b0;
      end else if (first) begin
        llat    <= 1'b1;
        op_q    <= op;
        lcd_e   <= op.module_sel ? 2'b10 : 2'b01;
        lcd_doe <= ~op.is_read;
        if (!op.is_read) lcd_dout <= host_wdata;
      end
      if (first && op.is_read)
        host_rdata <= '0;
      else if (complete && op_q.is_read)
        host_rdata <= lcd_din;
      else if (stat_acc && host_rd)
        host_rdata <= {{(DATA_W-STAT_W){1'b0}},
                       op_q.module_sel, op_q.is_read, op_q.is_cmd, llat};
    end
  end

  assign lcd_cmd = op_q.is_cmd;
  assign lcd_rw  = op_q.is_read;

  // R1: reset leaves the port idle
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (lcd_e == 2'b00 && !lcd_doe));
  // R3: never both strobes
  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lcd_e));
  // R4: latched write data holds while the pair is open
  assert_data_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (lcd_doe && !complete && !abort) |=> $stable(lcd_dout));
  // R5: a held host always faces a live strobe
  assert_wait_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    host_wait |-> (lcd_e != 2'b00));
  // R6: completion releases the strobes
  assert_pair_done_R6: assert property (@(posedge clk) disable iff (rst)
    complete |=> (lcd_e == 2'b00 && !lcd_doe));
  // R9: abort releases the strobes
  assert_abort_R9: assert property (@(posedge clk) disable iff (rst)
    abort |=> (lcd_e == 2'b00));
  // R10: status traffic never holds the host
  assert_stat_nowait_R10: assert property (@(posedge clk) disable iff (rst)
    stat_acc |-> !host_wait);
endmodule

// File: tb/lcd_pair_bridge_tb_top.sv
module lcd_pair_bridge_tb_top;
  localparam int H = 5;
  localparam int NV = 8;
  // {addr[2:0], wdata, din, exp strobe, exp read byte}
  localparam logic [28:0] VEC [NV] = '{
    {3'b000, 8'hA5, 8'h00, 2'b01, 8'h00},
    {3'b001, 8'h00, 8'h3C, 2'b01, 8'h3C},
    {3'b010, 8'h5A, 8'h00, 2'b01, 8'h00},
    {3'b011, 8'h00, 8'hC3, 2'b01, 8'hC3},
    {3'b100, 8'h81, 8'h00, 2'b10, 8'h00},
    {3'b101, 8'h00, 8'h7E, 2'b10, 8'h7E},
    {3'b110, 8'hFF, 8'h00, 2'b10, 8'h00},
    {3'b111, 8'h00, 8'h01, 2'b10, 8'h01}
  };

  logic clk = 0, rst = 1;
  logic [3:0] host_addr = '0;
  logic [7:0] host_wdata = '0, lcd_din = '0;
  logic host_rd = 0, host_wr = 0;
  logic [7:0] host_rdata, lcd_dout;
  logic host_wait, lcd_doe, lcd_cmd, lcd_rw;
  logic [1:0] lcd_e;
  int errors = 0, checks = 0, cycles = 0, waits;

  always #10 clk = ~clk;

  lcd_pair_bridge #(.HOLD_CLKS(H)) dut_i (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_wr(host_wr), .host_rdata(host_rdata),
    .host_wait(host_wait), .lcd_din(lcd_din), .lcd_dout(lcd_dout),
    .lcd_doe(lcd_doe), .lcd_cmd(lcd_cmd), .lcd_rw(lcd_rw), .lcd_e(lcd_e)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // first access: one cycle, then idle at the following negedge
  task automatic first_acc(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = {1'b0, a}; host_wdata = d;
    host_rd = a[0]; host_wr = ~a[0];
    @(negedge clk);
    host_rd = 0; host_wr = 0;
  endtask

  // second access presented now, held while host_wait
  task automatic second_acc(input logic [2:0] a, input logic [7:0] d,
                            input logic [7:0] keep_dout, input bit chk_dout);
    host_addr = {1'b0, a}; host_wdata = d;
    host_rd = a[0]; host_wr = ~a[0];
    waits = 0;
    #1;
    while (host_wait) begin
      waits++;
      if (chk_dout) chk(lcd_dout == keep_dout, "R7 dout held", lcd_dout, keep_dout);
      @(negedge clk); #1;
    end
    @(negedge clk);
    host_rd = 0; host_wr = 0;
  endtask

  task automatic stat_rd(output logic [7:0] v);
    @(negedge clk);
    host_addr = 4'b1000; host_rd = 1;
    #1; chk(!host_wait, "R10 no wait on status", host_wait, 0);
    @(negedge clk);
    host_rd = 0; v = host_rdata;
  endtask

  task automatic stat_wr(input logic [7:0] d);
    @(negedge clk);
    host_addr = 4'b1000; host_wdata = d; host_wr = 1;
    @(negedge clk);
    host_wr = 0;
  endtask

  initial begin
    logic [7:0] s;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk(lcd_e == 0, "R1 strobes", lcd_e, 0);
    chk(!lcd_doe, "R1 doe", lcd_doe, 0);
    chk(!host_wait, "R1 wait", host_wait, 0);
    stat_rd(s);
    chk(s == 0, "R1 status", s, 0);

    for (int i = 0; i < NV; i++) begin
      logic [2:0] a; logic [7:0] wd, dn, er; logic [1:0] ee;
      {a, wd, dn, ee, er} = VEC[i];
      lcd_din = dn;
      first_acc(a, wd);
      chk(lcd_e == ee, "R2 R3 strobe", lcd_e, ee);
      chk(lcd_cmd == ~a[1], "R2 cmd", lcd_cmd, ~a[1]);
      chk(lcd_rw == a[0], "R2 rw", lcd_rw, a[0]);
      if (a[0]) chk(host_rdata == 0, "R2 first read zero", host_rdata, 0);
      else begin
        chk(lcd_doe, "R4 doe", lcd_doe, 1);
        chk(lcd_dout == wd, "R4 dout", lcd_dout, wd);
      end
      second_acc(a, ~wd, wd, !a[0]);
      chk(waits == H - 1, "R5 wait cycles", waits, H - 1);
      chk(lcd_e == 0, "R6 strobes off", lcd_e, 0);
      if (a[0]) chk(host_rdata == er, "R6 read data", host_rdata, er);
      stat_rd(s);
      chk(s == {4'b0, a[2], a[0], ~a[1], 1'b0}, "R8 status after pair", s,
          {4'b0, a[2], a[0], ~a[1], 1'b0});
    end

    // R8 R10: status while pending
    lcd_din = 8'h66;
    first_acc(3'b011, 8'h00);
    stat_rd(s);
    chk(s == 8'h05, "R8 status pending", s, 8'h05);
    stat_rd(s);
    chk(s == 8'h05, "R10 pair still pending", s, 8'h05);
    // R9: write without abort bit does nothing
    stat_wr(8'h07);
    chk(lcd_e == 2'b01, "R9 no-abort strobe", lcd_e, 2'b01);
    stat_rd(s);
    chk(s == 8'h05, "R9 no-abort status", s, 8'h05);
    stat_wr(8'h08);
    chk(lcd_e == 0, "R9 abort strobes", lcd_e, 0);
    stat_rd(s);
    chk(s[0] == 0, "R9 abort flag", s[0], 0);

    // R7: new first access after abort; completed by a different address
    first_acc(3'b100, 8'h42);
    chk(lcd_e == 2'b10, "R2 after abort", lcd_e, 2'b10);
    stat_rd(s);
    chk(s == 8'h0B, "R8 status module1", s, 8'h0B);
    second_acc(3'b010, 8'h99, 8'h42, 1);
    chk(lcd_e == 0, "R7 done by other address", lcd_e, 0);
    stat_rd(s);
    chk(s == 8'h0A, "R7 latched op kept", s, 8'h0A);

    // R5: late second access sees no wait
    lcd_din = 8'h5C;
    first_acc(3'b101, 8'h00);
    repeat (H + 2) @(negedge clk);
    chk(lcd_e == 2'b10, "R5 strobe held", lcd_e, 2'b10);
    second_acc(3'b101, 8'h00, 8'h00, 0);
    chk(waits == 0, "R5 late no wait", waits, 0);
    chk(host_rdata == 8'h5C, "R6 late read", host_rdata, 8'h5C);

    // R1: reset mid-pair
    first_acc(3'b000, 8'h11);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk(lcd_e == 0 && !lcd_doe, "R1 reset mid-pair", lcd_e, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule